// File: doc/BRIEF.md
# Two-Wire Bus Four-Byte Write Sequencer

This block drives a byte-level two-wire bus engine through one complete controller-side write. A one-cycle `go_i` pulse captures a target address byte, which already carries the read/write bit in its lowest position, and a 32-bit payload. The sequencer then commands the engine through a start condition, the address byte, and four payload bytes, and finishes with a stop condition. The engine is modelled as a command strobe with an opcode and a byte, plus a `eng_done_i` pulse that carries a status code.

Each time the engine reports completion, the sequencer masks off the three low status bits, which are prescaler bits, and compares the rest with the code that phase should produce. If any phase returns an unexpected code, the sequencer does not send a stop. It commands the engine to release the bus and disable itself, and it returns to idle. It also publishes an 8-bit error indicator that encodes how many completion reports had arrived, counting the failing one.

Top module: `twowire_wr_seq`

## Requirements
- R1: After reset, `busy_o`, `cmd_valid_o`, `ok_o` and `err_o` are 0, and `err_code_o` is 0xFF.
- R2: A `go_i` pulse seen while idle produces, in the next cycle, a command strobe with opcode START (0), and `busy_o` goes high.
- R3: After each accepted completion, except the last, the next command is WRITE (1). The WRITE bytes go out in this order: the target address, then `payload_i[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R4: The status is compared after masking with 0xF8, so its three low bits have no effect. The expected code is 0x08 after START, 0x18 after the address byte and 0x28 after each payload byte.
- R5: When the status for the fourth payload byte matches, the next cycle carries a STOP (2) strobe and a one-cycle `ok_o` pulse, and `busy_o` is low.
- R6: On any status mismatch, the next cycle carries a RELEASE (3) strobe and a one-cycle `err_o` pulse, `busy_o` is low, and no STOP is issued.
- R7: The phase count is cleared when a transaction starts and increments on every completion before that completion's status is checked. On error, `err_code_o` becomes the bitwise complement of (0x50 OR count) and holds until the next start. A start restores it to 0xFF.
- R8: A `go_i` pulse while busy is ignored: no strobe follows it and the running sequence continues unchanged. Changes on `tgt_addr_i` or `payload_i` after the start have no effect.
- R9: Every command is a single-cycle strobe, issued only in the cycle after a start or after a completion report. While the engine has not reported, no command is issued.
- R10: `eng_done_i` while idle is ignored and produces no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Start pulse |
| tgt_addr_i | input | 8 | Address byte including read/write bit |
| payload_i | input | 32 | Four payload bytes, most significant sent first |
| eng_done_i | input | 1 | Engine phase-complete pulse |
| eng_status_i | input | 8 | Engine status code, valid with eng_done_i |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 2 | 0 START, 1 WRITE, 2 STOP, 3 RELEASE |
| cmd_byte_o | output | 8 | Byte for a WRITE command |
| busy_o | output | 1 | Transaction in progress |
| ok_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 8 | Failure indicator, 0xFF when none |

## Verification
The bench injects a wrong code at every one of the six phases, and it sets every value of the three prescaler bits on every phase. A design that compared unmasked status would abort good transactions. One that checked the wrong code would accept the address code after a start, or the start code after the address byte, because the injected fault swaps those two codes. One that miscounted would report an error code off by one phase.

The bench also pulses `go_i` in the middle of a transaction and rewrites the inputs after the start. A design that restarted or re-sampled would emit a stray START or the wrong bytes. Completions while idle would show up as spurious strobes, and a stop sent on failure would show up as a STOP opcode instead of RELEASE.

// File: rtl/twowire_wr_pkg.sv
`timescale 1ns/1ps
package twowire_wr_pkg;

    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_WRITE   = 2'd1,
        OP_STOP    = 2'd2,
        OP_RELEASE = 2'd3
    } tw_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } tw_state_e;

    localparam logic [7:0] STATUS_MASK = 8'hF8;
    localparam logic [7:0] CODE_START  = 8'h08;
    localparam logic [7:0] CODE_ADDR   = 8'h18;
    localparam logic [7:0] CODE_DATA   = 8'h28;
    localparam logic [7:0] ERR_MARK    = 8'h50;
    localparam logic [7:0] CODE_NONE   = 8'hFF;

endpackage

// File: rtl/twowire_status_chk.sv
`timescale 1ns/1ps
// Compares masked engine status with the code expected for a phase.
// Phase 0 is the start condition, phase 1 the address byte, higher ones data.
module twowire_status_chk
    import twowire_wr_pkg::*;
#(
    parameter int PH_W = 3
) (
    input  logic [PH_W-1:0] phase_i,
    input  logic [7:0]      status_i,
    output logic            match_o
);
    logic [7:0] expect_code;

    always_comb begin
        if (phase_i == '0)
            expect_code = CODE_START;
        else if (phase_i == PH_W'(1))
            expect_code = CODE_ADDR;
        else
            expect_code = CODE_DATA;
    end

    assign match_o = ((status_i & STATUS_MASK) == expect_code);
endmodule

// File: rtl/twowire_byte_sel.sv
`timescale 1ns/1ps
// Selects the byte carried by a write phase: phase 1 is the address,
// phases 2.. are payload bytes, most significant first.
module twowire_byte_sel #(
    parameter int NUM_DATA = 4,
    parameter int PH_W     = 3
) (
    input  logic [PH_W-1:0]       phase_i,
    input  logic [7:0]            addr_i,
    input  logic [NUM_DATA*8-1:0] data_i,
    output logic [7:0]            byte_o
);
    localparam int NUM_LANES = NUM_DATA + 2;

    logic [7:0] lane [NUM_LANES];

    assign lane[0] = 8'h00;
    assign lane[1] = addr_i;

    for (genvar g = 0; g < NUM_DATA; g++) begin : g_lane
        assign lane[g+2] = data_i[(NUM_DATA-1-g)*8 +: 8];
    end

    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (phase_i == PH_W'(i))
                byte_o = lane[i];
        end
    end
endmodule

// File: rtl/twowire_wr_seq.sv
`timescale 1ns/1ps
module twowire_wr_seq
    import twowire_wr_pkg::*;
#(
    parameter int NUM_DATA = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go_i,
    input  logic [7:0]            tgt_addr_i,
    input  logic [NUM_DATA*8-1:0] payload_i,
    input  logic                  eng_done_i,
    input  logic [7:0]            eng_status_i,
    output logic                  cmd_valid_o,
    output logic [1:0]            cmd_op_o,
    output logic [7:0]            cmd_byte_o,
    output logic                  busy_o,
    output logic                  ok_o,
    output logic                  err_o,
    output logic [7:0]            err_code_o
);
    localparam int NUM_PHASES = NUM_DATA + 2;
    localparam int PH_W       = $clog2(NUM_PHASES + 1);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PHASES - 1);

    typedef struct packed {
        tw_state_e             st;
        logic [PH_W-1:0]       ph;
        logic [PH_W-1:0]       cnt;
        logic [7:0]            addr;
        logic [NUM_DATA*8-1:0] data;
        logic                  cmd_v;
        tw_op_e                op;
        logic [7:0]            cmd_b;
        logic                  ok;
        logic                  err;
        logic [7:0]            code;
    } seq_t;

    seq_t q, d;

    logic [PH_W-1:0] ph_next;
    logic [PH_W-1:0] cnt_inc;
    logic [7:0]      next_byte;
    logic            status_ok;

    assign ph_next = q.ph + 1'b1;
    assign cnt_inc = q.cnt + 1'b1;

    twowire_status_chk #(.PH_W(PH_W)) chk_i (
        .phase_i  (q.ph),
        .status_i (eng_status_i),
        .match_o  (status_ok)
    );

    twowire_byte_sel #(.NUM_DATA(NUM_DATA), .PH_W(PH_W)) sel_i (
        .phase_i (ph_next),
        .addr_i  (q.addr),
        .data_i  (q.data),
        .byte_o  (next_byte)
    );

    always_comb begin
        d       = q;
        d.cmd_v = 1'b0;
        d.cmd_b = 8'h00;
        d.ok    = 1'b0;
        d.err   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (go_i) begin
                    d.st    = ST_WAIT;
                    d.ph    = '0;
                    d.cnt   = '0;
                    d.addr  = tgt_addr_i;
                    d.data  = payload_i;
                    d.cmd_v = 1'b1;
                    d.op    = OP_START;
                    d.code  = CODE_NONE;
                end
            end
            ST_WAIT: begin
                if (eng_done_i) begin
                    d.cnt   = cnt_inc;
                    d.cmd_v = 1'b1;
                    if (!status_ok) begin
                        d.st   = ST_IDLE;
                        d.op   = OP_RELEASE;
                        d.err  = 1'b1;
                        d.code = ~(ERR_MARK | {{(8-PH_W){1'b0}}, cnt_inc});
                    end else if (q.ph == LAST_PH) begin
                        d.st = ST_IDLE;
                        d.op = OP_STOP;
                        d.ok = 1'b1;
                    end else begin
                        d.ph    = ph_next;
                        d.op    = OP_WRITE;
                        d.cmd_b = next_byte;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.op    <= OP_START;
            q.code  <= CODE_NONE;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid_o = q.cmd_v;
    assign cmd_op_o    = q.op;
    assign cmd_byte_o  = q.cmd_b;
    assign busy_o      = (q.st == ST_WAIT);
    assign ok_o        = q.ok;
    assign err_o       = q.err;
    assign err_code_o  = q.code;

    // R2: an accepted start yields a START strobe and busy.
    a_r2_start_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !busy_o) |=> (busy_o && cmd_valid_o && cmd_op_o == 2'd0));

    // R8: a start while busy produces no strobe unless the engine reported.
    a_r8_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && busy_o && !eng_done_i) |=> !cmd_valid_o);

    // R9: a command only follows a start or a completion report.
    a_r9_cmd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> ($past(go_i) || $past(eng_done_i)));

    // R10: idle with no start means no command next cycle.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !go_i) |=> !cmd_valid_o);

    // R5: a stop ends the transaction with a success pulse.
    a_r5_stop_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == 2'd2) |-> (ok_o && !busy_o && !err_o));

    // R6: failure releases the bus and leaves busy low.
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (cmd_valid_o && cmd_op_o == 2'd3 && !busy_o));

    // R7: an error code always carries the marker pattern, inverted.
    a_r7_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_code_o[7] && !err_code_o[6] && !err_code_o[4]));

endmodule

// File: tb/twowire_wr_seq_tb_top.sv
`timescale 1ns/1ps
module twowire_wr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        go_i;
    logic [7:0]  tgt_addr_i;
    logic [31:0] payload_i;
    logic        eng_done_i;
    logic [7:0]  eng_status_i;
    logic        cmd_valid_o;
    logic [1:0]  cmd_op_o;
    logic [7:0]  cmd_byte_o;
    logic        busy_o;
    logic        ok_o;
    logic        err_o;
    logic [7:0]  err_code_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    twowire_wr_seq #(.NUM_DATA(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .tgt_addr_i(tgt_addr_i),
        .payload_i(payload_i), .eng_done_i(eng_done_i), .eng_status_i(eng_status_i),
        .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_byte_o(cmd_byte_o),
        .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input int ph, input logic [7:0] a,
                                            input logic [31:0] p);
        if (ph == 1) return a;
        return p[(5-ph)*8 +: 8];
    endfunction

    task automatic run_txn(input logic [7:0] a, input logic [31:0] p,
                           input int fail_ph, input logic [2:0] noise, input bit poke);
        logic [7:0] ecode;
        int dly;
        go_i = 1'b1; tgt_addr_i = a; payload_i = p;
        tick();
        go_i = 1'b0;
        if (poke) begin tgt_addr_i = ~a; payload_i = ~p; end
        chk(cmd_valid_o && cmd_op_o == 2'd0, "R2", "start strobe/op", {cmd_valid_o, cmd_op_o}, 3'b100);
        chk(busy_o, "R2", "busy after start", busy_o, 1);
        chk(err_code_o == 8'hFF, "R7", "code cleared at start", err_code_o, 8'hFF);
        for (int ph = 0; ph < 6; ph++) begin
            ecode = (ph == 0) ? 8'h08 : (ph == 1) ? 8'h18 : 8'h28;
            dly = (ph + noise) % 3;
            if (poke && ph == 1 && dly == 0) dly = 1;
            for (int k = 0; k < dly; k++) begin
                if (poke && ph == 1 && k == 0) go_i = 1'b1;
                tick();
                go_i = 1'b0;
                chk(!cmd_valid_o, "R9", "no strobe while waiting (R8 when poked)", cmd_valid_o, 0);
                chk(busy_o, "R8", "still busy", busy_o, 1);
            end
            eng_done_i   = 1'b1;
            eng_status_i = ((ph == fail_ph) ? (ecode ^ 8'h10) : ecode) | {5'b0, noise};
            tick();
            eng_done_i   = 1'b0;
            eng_status_i = 8'h00;
            if (ph == fail_ph) begin
                chk(cmd_valid_o && cmd_op_o == 2'd3, "R6", "release strobe", {cmd_valid_o, cmd_op_o}, 3'b111);
                chk(err_o && !ok_o && !busy_o, "R6", "err/ok/busy", {err_o, ok_o, busy_o}, 3'b100);
                chk(err_code_o == ~(8'h50 | 8'(ph + 1)), "R7", "error code", err_code_o, ~(8'h50 | 8'(ph + 1)));
                tick();
                chk(!cmd_valid_o && !err_o, "R9", "single-cycle release", {cmd_valid_o, err_o}, 0);
                chk(err_code_o == ~(8'h50 | 8'(ph + 1)), "R7", "code held", err_code_o, ~(8'h50 | 8'(ph + 1)));
                return;
            end else if (ph == 5) begin
                chk(cmd_valid_o && cmd_op_o == 2'd2, "R5", "stop strobe", {cmd_valid_o, cmd_op_o}, 3'b110);
                chk(ok_o && !err_o && !busy_o, "R5", "ok/err/busy", {ok_o, err_o, busy_o}, 3'b100);
                chk(err_code_o == 8'hFF, "R7", "no error code", err_code_o, 8'hFF);
                tick();
                chk(!cmd_valid_o && !ok_o, "R9", "single-cycle stop", {cmd_valid_o, ok_o}, 0);
            end else begin
                chk(cmd_valid_o && cmd_op_o == 2'd1, "R4", "write strobe after good masked status",
                    {cmd_valid_o, cmd_op_o}, 3'b101);
                chk(cmd_byte_o == exp_byte(ph + 1, a, p), "R3", "write byte order",
                    cmd_byte_o, exp_byte(ph + 1, a, p));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; go_i = 1'b0; tgt_addr_i = 8'h00; payload_i = 32'h0;
        eng_done_i = 1'b0; eng_status_i = 8'h00;
        repeat (3) tick();
        chk(!busy_o && !cmd_valid_o && !ok_o && !err_o, "R1", "reset outputs",
            {busy_o, cmd_valid_o, ok_o, err_o}, 0);
        chk(err_code_o == 8'hFF, "R1", "reset code", err_code_o, 8'hFF);
        rst_n = 1'b1;
        tick();
        // R10: completion while idle
        eng_done_i = 1'b1; eng_status_i = 8'h08;
        tick();
        eng_done_i = 1'b0; eng_status_i = 8'h00;
        chk(!cmd_valid_o && !busy_o, "R10", "idle done ignored", {cmd_valid_o, busy_o}, 0);
        tick();
        chk(!cmd_valid_o && !busy_o, "R10", "idle done still quiet", {cmd_valid_o, busy_o}, 0);
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 7; f++) begin
                for (int nz = 0; nz < 8; nz++) begin
                    run_txn((s == 0) ? 8'hA4 : 8'h3B,
                            (s == 0) ? 32'h1234_C0DE : 32'hF00D_5A81,
                            f, 3'(nz), (nz == 5));
                    tick();
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule